// File: doc/BRIEF.md
# Table-Driven String Search Engine

This block scans a byte-wide text held in on-chip memory for every occurrence of a search pattern. It uses the search phase of the Knuth-Morris-Pratt method. The pattern itself is never stored. All pattern-specific behaviour sits in two small writable tables indexed by the current match state:

- an expected-character table, giving the character that state must see next;
- a fail-state table, giving the state to fall back to after a mismatch or after a complete match.

The host computes both tables from the pattern's border (prefix) lengths. It writes them, together with the pattern length, before each search. Changing the pattern is therefore a memory rewrite, not a rebuild.

A search starts on a pulse of `start` and performs exactly one iteration per clock, whatever the pattern length. While it runs, the engine counts occurrences and pushes the start address of each one into a result FIFO. The host drains that FIFO after or during the search. `done` stays high from the end of the search until the next accepted start.

Top module: `kmp_search_engine`

## Requirements
- R1: After reset, and in the cycle after an accepted start, `busy`, `done`, `overflow`, `resValid` and `matchCount` are all 0, apart from `busy`, which becomes 1 after a start.
- R2: Every exact occurrence of the pattern is counted in `matchCount`, including overlapping ones. A text containing no occurrence gives a count of 0.
- R3: The start address of each occurrence, equal to the address of its first character, is delivered on `resAddr` in text order. `resValid` marks a valid head, and `resPop` removes it.
- R4: One search iteration is performed per cycle. Each iteration takes one of three actions:
  - On a character hit, it moves to the next state and to the next address.
  - On a miss in state 0, it moves to the next address.
  - On a miss in any other state, it loads that state's fail entry and stays at the same address.
  
  `busy` is high for exactly as many cycles as there are iterations.
- R5: The search ends when the last text address (`textLen`−1) is passed. At that point `busy` falls and `done` rises, and `done` holds until the next accepted start.
- R6: Writes to the text memory or to the tables are ignored while `busy` is high.
- R7: A `start` pulse while `busy` is high is ignored.
- R8: The FIFO holds 32 start addresses. Once it is full, further occurrences are dropped from the FIFO but still counted, and `overflow` is set and stays set until the next accepted start.
- R9: Pattern lengths from 3 to 20 are supported. Table entry k, for k from 0 to length−1, holds the pattern character at position k. Fail entry k, for k from 1 to length, holds the border length of the first k pattern characters. On a complete match, the engine takes fail entry `patLen`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| textWe | input | 1 | Text memory write enable |
| textWrAddr | input | 11 | Text write address |
| textWrData | input | 8 | Text write byte |
| tblWe | input | 1 | Table write enable (both tables at one index) |
| tblIdx | input | 5 | State index of the table write |
| tblChar | input | 8 | Expected character for that state |
| tblFail | input | 5 | Fail state for that state |
| patLen | input | 5 | Pattern length, latched at start |
| textLen | input | 12 | Number of text characters (1 to 2048), latched at start |
| start | input | 1 | Start pulse, accepted only when idle |
| busy | output | 1 | Search in progress |
| done | output | 1 | Search finished, sticky until next start |
| matchCount | output | 12 | Occurrences found |
| overflow | output | 1 | An occurrence did not fit in the FIFO |
| resValid | output | 1 | FIFO head is valid |
| resAddr | output | 11 | Start address at the FIFO head |
| resPop | input | 1 | Remove the FIFO head |

## Verification
The assertions take for granted that the host keeps `textLen` at 1 or more, keeps `patLen` between 3 and 20, and writes tables that follow R9, so that fail entries never point at or above the state they belong to. The stimulus builds every table in the bench from the pattern's own border lengths and only searches texts loaded in full beforehand. The only out-of-rule traffic it produces is the deliberate writes and start pulse issued while a search runs, which must be ignored.

// File: rtl/kmp_pkg.sv
package kmp_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic clear;   // accepted start: reinitialise search state
    logic step;    // perform one search iteration
    logic wrOk;    // host writes allowed
  } ctlStrobes_t;
endpackage

// File: rtl/kmp_result_fifo.sv
module kmp_result_fifo #(
  parameter int DEPTH  = 32,
  parameter int DATA_W = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              flush,
  input  logic              push,
  input  logic [DATA_W-1:0] pushData,
  input  logic              pop,
  output logic              full,
  output logic              notEmpty,
  output logic [DATA_W-1:0] headData
);
  localparam int PTR_W = $clog2(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [PTR_W:0]    fill;
  logic              doPush, doPop;

  assign full     = (fill == (PTR_W+1)'(DEPTH));
  assign notEmpty = (fill != '0);
  assign doPush   = push && !full;
  assign doPop    = pop && notEmpty;
  assign headData = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush && !flush) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      fill  <= '0;
    end else if (flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      fill  <= '0;
    end else begin
      if (doPush) wrPtr <= wrPtr + 1'b1;
      if (doPop)  rdPtr <= rdPtr + 1'b1;
      case ({doPush, doPop})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end
endmodule

// File: rtl/kmp_ctrl.sv
module kmp_ctrl
  import kmp_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        lastIter,
  output logic        busy,
  output logic        done,
  output ctlStrobes_t ctl
);
  logic accept;
  assign accept = start && !busy;

  always_comb begin
    ctl.clear = accept;
    ctl.step  = busy;
    ctl.wrOk  = !busy;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy <= 1'b0;
      done <= 1'b0;
    end else if (accept) begin
      busy <= 1'b1;
      done <= 1'b0;
    end else if (busy && lastIter) begin
      busy <= 1'b0;
      done <= 1'b1;
    end
  end
endmodule

// File: rtl/kmp_datapath.sv
module kmp_datapath
  import kmp_pkg::*;
#(
  parameter int ADDR_W  = 11,
  parameter int STATE_W = 5,
  parameter int CNT_W   = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobes_t        ctl,
  input  logic               textWe,
  input  logic [ADDR_W-1:0]  textWrAddr,
  input  logic [7:0]         textWrData,
  input  logic               tblWe,
  input  logic [STATE_W-1:0] tblIdx,
  input  logic [7:0]         tblChar,
  input  logic [STATE_W-1:0] tblFail,
  input  logic [STATE_W-1:0] patLen,
  input  logic [ADDR_W:0]    textLen,
  input  logic               fifoFull,
  output logic               lastIter,
  output logic               pushValid,
  output logic [ADDR_W-1:0]  pushAddr,
  output logic [CNT_W-1:0]   matchCount,
  output logic               overflow
);
  localparam int TEXT_DEPTH = 1 << ADDR_W;
  localparam int TAB_DEPTH  = 1 << STATE_W;

  logic [7:0]         textMem [TEXT_DEPTH];
  logic [7:0]         charTab [TAB_DEPTH];
  logic [STATE_W-1:0] failTab [TAB_DEPTH];

  logic [STATE_W-1:0] state, patLenR;
  logic [ADDR_W-1:0]  addr, lastAddr;
  logic               hit, finalHit, advance;

  // host-side table and text writes, blocked during a search
  always_ff @(posedge clk) begin
    if (ctl.wrOk && textWe) textMem[textWrAddr] <= textWrData;
    if (ctl.wrOk && tblWe) begin
      charTab[tblIdx] <= tblChar;
      failTab[tblIdx] <= tblFail;
    end
  end

  assign hit       = (textMem[addr] == charTab[state]);
  assign finalHit  = hit && (state == patLenR - 1'b1);
  assign advance   = hit || (state == '0);
  assign lastIter  = ctl.step && advance && (addr == lastAddr);
  assign pushValid = ctl.step && finalHit;
  assign pushAddr  = addr - ADDR_W'(patLenR) + 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= '0;
      addr       <= '0;
      patLenR    <= '0;
      lastAddr   <= '0;
      matchCount <= '0;
      overflow   <= 1'b0;
    end else if (ctl.clear) begin
      state      <= '0;
      addr       <= '0;
      patLenR    <= patLen;
      lastAddr   <= ADDR_W'(textLen - 1'b1);
      matchCount <= '0;
      overflow   <= 1'b0;
    end else if (ctl.step) begin
      if (hit) begin
        state <= finalHit ? failTab[patLenR] : state + 1'b1;
      end else if (state != '0) begin
        state <= failTab[state];
      end
      if (advance) addr <= addr + 1'b1;
      if (finalHit) begin
        matchCount <= matchCount + 1'b1;
        if (fifoFull) overflow <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/kmp_search_engine.sv
module kmp_search_engine
  import kmp_pkg::*;
#(
  parameter int ADDR_W     = 11,
  parameter int MAX_PAT    = 20,
  parameter int FIFO_DEPTH = 32,
  parameter int STATE_W    = $clog2(MAX_PAT + 1),
  parameter int CNT_W      = ADDR_W + 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               textWe,
  input  logic [ADDR_W-1:0]  textWrAddr,
  input  logic [7:0]         textWrData,
  input  logic               tblWe,
  input  logic [STATE_W-1:0] tblIdx,
  input  logic [7:0]         tblChar,
  input  logic [STATE_W-1:0] tblFail,
  input  logic [STATE_W-1:0] patLen,
  input  logic [ADDR_W:0]    textLen,
  input  logic               start,
  output logic               busy,
  output logic               done,
  output logic [CNT_W-1:0]   matchCount,
  output logic               overflow,
  output logic               resValid,
  output logic [ADDR_W-1:0]  resAddr,
  input  logic               resPop
);
  ctlStrobes_t       ctl;
  logic              lastIter, pushValid, fifoFull;
  logic [ADDR_W-1:0] pushAddr;

  kmp_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .lastIter(lastIter),
    .busy(busy), .done(done), .ctl(ctl)
  );

  kmp_datapath #(.ADDR_W(ADDR_W), .STATE_W(STATE_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .textWe(textWe), .textWrAddr(textWrAddr), .textWrData(textWrData),
    .tblWe(tblWe), .tblIdx(tblIdx), .tblChar(tblChar), .tblFail(tblFail),
    .patLen(patLen), .textLen(textLen), .fifoFull(fifoFull),
    .lastIter(lastIter), .pushValid(pushValid), .pushAddr(pushAddr),
    .matchCount(matchCount), .overflow(overflow)
  );

  kmp_result_fifo #(.DEPTH(FIFO_DEPTH), .DATA_W(ADDR_W)) u_fifo (
    .clk(clk), .rstN(rstN), .flush(ctl.clear),
    .push(pushValid), .pushData(pushAddr), .pop(resPop),
    .full(fifoFull), .notEmpty(resValid), .headData(resAddr)
  );
endmodule

// File: rtl/kmp_search_chk.sv
module kmp_search_chk #(
  parameter int CNT_W = 12
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic [CNT_W-1:0] matchCount,
  input logic             overflow,
  input logic             resValid
);
  // R5
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(busy && done));

  // R5
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    done && !start |=> done);

  // R5
  end_flags_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);

  // R1
  start_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    start && !busy |=> busy && !done && !overflow && !resValid && (matchCount == '0));

  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(start && !busy) |=> (matchCount == $past(matchCount)) ||
                          (matchCount == $past(matchCount) + 1'b1));

  // R8
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    overflow && !(start && !busy) |=> overflow);

  // R7
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy && start |=> !done || !busy);
endmodule

bind kmp_search_engine kmp_search_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .busy(busy), .done(done),
  .matchCount(matchCount), .overflow(overflow), .resValid(resValid)
);

// File: tb/sim_kmp_search_engine.sv
module sim_kmp_search_engine;
  localparam int ADDR_W = 11, STATE_W = 5, CNT_W = 12, FIFO_DEPTH = 32;

  logic clk = 1'b0, rstN = 1'b0;
  logic textWe = 0, tblWe = 0, start = 0, resPop = 1'b0;
  logic [ADDR_W-1:0] textWrAddr = '0;
  logic [7:0] textWrData = '0, tblChar = '0;
  logic [STATE_W-1:0] tblIdx = '0, tblFail = '0, patLen = '0;
  logic [ADDR_W:0] textLen = '0;
  logic busy, done, overflow, resValid;
  logic [CNT_W-1:0] matchCount;
  logic [ADDR_W-1:0] resAddr;

  int total = 0, bad = 0;
  int expQ[$];
  bit monEn = 1'b1;

  always #10 clk = ~clk;

  kmp_search_engine u0 (
    .clk(clk), .rstN(rstN), .textWe(textWe), .textWrAddr(textWrAddr),
    .textWrData(textWrData), .tblWe(tblWe), .tblIdx(tblIdx), .tblChar(tblChar),
    .tblFail(tblFail), .patLen(patLen), .textLen(textLen), .start(start),
    .busy(busy), .done(done), .matchCount(matchCount), .overflow(overflow),
    .resValid(resValid), .resAddr(resAddr), .resPop(resPop)
  );

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: pops FIFO entries and compares with the scoreboard queue (R3)
  always @(negedge clk) begin
    resPop = 1'b0;
    if (rstN && monEn && resValid) begin
      if (expQ.size() == 0) chk(1'b0, "R3 unexpected result", int'(resAddr), -1);
      else begin
        int e;
        e = expQ.pop_front();
        chk(int'(resAddr) == e, "R3 start address", int'(resAddr), e);
      end
      resPop = 1'b1;
    end
  end

  task automatic loadText(string txt);
    for (int i = 0; i < txt.len(); i++) begin
      textWe = 1'b1; textWrAddr = ADDR_W'(i); textWrData = txt[i];
      @(negedge clk);
    end
    textWe = 1'b0;
  endtask

  // host role: border lengths -> tables (R9)
  task automatic loadTables(string pat);
    int pi[32];
    int m, k;
    m = pat.len(); k = 0; pi[0] = 0;
    for (int q = 1; q < m; q++) begin
      while (k > 0 && pat[k] != pat[q]) k = pi[k-1];
      if (pat[k] == pat[q]) k++;
      pi[q] = k;
    end
    for (int i = 0; i <= m; i++) begin
      tblWe = 1'b1; tblIdx = STATE_W'(i);
      tblChar = (i < m) ? pat[i] : 8'h00;
      tblFail = (i == 0) ? '0 : STATE_W'(pi[i-1]);
      @(negedge clk);
    end
    tblWe = 1'b0;
  endtask

  // expected iteration count from the R4 rules
  function automatic int iterCount(string txt, string pat);
    int pi[32];
    int m, n, k, s, a, it;
    m = pat.len(); n = txt.len(); k = 0; pi[0] = 0;
    for (int q = 1; q < m; q++) begin
      while (k > 0 && pat[k] != pat[q]) k = pi[k-1];
      if (pat[k] == pat[q]) k++;
      pi[q] = k;
    end
    s = 0; a = 0; it = 0;
    while (a < n) begin
      it++;
      if (txt[a] == pat[s]) begin
        s = (s == m-1) ? pi[m-1] : s + 1;
        a++;
      end else if (s == 0) a++;
      else s = pi[s-1];
    end
    return it;
  endfunction

  // driver: loads, starts, measures, and fills the scoreboard
  task automatic runSearch(string txt, string pat, bit reload, bit disturb);
    int occ, cyc, expIt, waitN;
    if (reload) begin loadText(txt); loadTables(pat); end
    occ = 0;
    for (int i = 0; i + pat.len() <= txt.len(); i++)
      if (txt.substr(i, i + pat.len() - 1) == pat) begin
        if (occ < FIFO_DEPTH) expQ.push_back(i);
        occ++;
      end
    expIt = iterCount(txt, pat);
    monEn = (occ <= FIFO_DEPTH);
    patLen = STATE_W'(pat.len()); textLen = (ADDR_W+1)'(txt.len());
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy && !done && matchCount == 0, "R1/R5 after start", int'(done), 0);
    cyc = 0;
    while (busy && cyc < 5000) begin
      cyc++;
      textWe = 1'b0; tblWe = 1'b0; start = 1'b0;
      if (disturb && cyc == 2) begin
        textWe = 1'b1; textWrAddr = '0; textWrData = 8'h7a;
        tblWe = 1'b1; tblIdx = 5'd1; tblChar = 8'h7a; tblFail = '0;
      end
      if (disturb && cyc == 4) start = 1'b1;
      @(negedge clk);
    end
    textWe = 1'b0; tblWe = 1'b0; start = 1'b0;
    chk(cyc == expIt, "R4 busy cycles", cyc, expIt);
    chk(done, "R5 done raised", int'(done), 1);
    chk(int'(matchCount) == occ, "R2 match count", int'(matchCount), occ);
    chk(overflow == (occ > FIFO_DEPTH), "R8 overflow flag", int'(overflow), int'(occ > FIFO_DEPTH));
    repeat (3) @(negedge clk);
    chk(done, "R5 done sticky", int'(done), 1);
    monEn = 1'b1;
    waitN = 0;
    while (expQ.size() != 0 && waitN < 200) begin waitN++; @(negedge clk); end
    @(negedge clk);
    chk(expQ.size() == 0 && !resValid, "R3 fifo drained", expQ.size(), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !overflow && !resValid && matchCount == 0, "R1 reset state", int'(busy), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!busy && !done, "R1 after release", int'(done), 0);
    // R2 R3 R4 overlapping KMP-style pattern
    runSearch("abababcaababcaxababcaababca", "ababca", 1'b1, 1'b0);
    // R2 overlapping runs of a single letter, length 3 (R9)
    runSearch("aaaaaaaa", "aaa", 1'b1, 1'b0);
    // R9 length-20 pattern with a near miss
    runSearch("xxabcdeabcdeabcdeabcdxqabcdeabcdeabcdeabcdyabcdeabcdeabcdeabcdx",
              "abcdeabcdeabcdeabcdx", 1'b1, 1'b0);
    // R2 no occurrence
    runSearch("xyzxyzxyz", "abc", 1'b1, 1'b0);
    // R6 R7 writes and start during a search are ignored, then rerun without reload
    runSearch("abababcaababcaxababcaababca", "ababca", 1'b1, 1'b1);
    runSearch("abababcaababcaxababcaababca", "ababca", 1'b0, 1'b0);
    // R8 more occurrences than FIFO entries
    runSearch("aaaaaaaaaaaaaaaaaaaaaaaaaaaaaaaaaaaaaaaa", "aaa", 1'b1, 1'b0);
    // R8 flag clears on next start
    runSearch("abcab", "cab", 1'b1, 1'b0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule